// File: doc/BRIEF.md
# Logical Interrupt Destination Matcher

This block sits beside a local interrupt controller and decides, for each inter-processor message sent with a logical destination, whether this unit is one of the targets. Software programs two 32-bit registers through a small write/read port. The logical-ID register holds this unit's 8-bit logical identity in its top byte. The format register holds a 4-bit model selector in its top nibble.

Two addressing models are supported. In the flat model, each set bit of the 8-bit destination names one unit. In the cluster model, the top nibble of the destination is an encoded cluster number and the low nibble is a mask of members inside that cluster. Every message gets exactly one registered, one-cycle outcome: accept, ignore or error. The error outcome is for a lowest-priority broadcast in the cluster model, which is not supported. A model selector that is neither of the two legal codes makes the block ignore all traffic and raise a sticky configuration flag.

Top module: `ldest_match`

## Requirements
- R1: After reset, the logical-ID register reads 0x00000000, the format register reads 0xFFFFFFFF (flat model), cfg_err is 0, and accept, ignore and error are 0.
- R2: Address 0 selects the logical-ID register, which stores write bits 31:24 and reads bits 23:0 as zero. Address 1 selects the format register, which stores write bits 31:28 and reads bits 27:0 as ones. reg_rdata shows the register chosen by reg_addr, and a write is visible from the following cycle.
- R3: accept, ignore and error are registered. For a message presented with msg_valid in one cycle, exactly one of them is high during the next cycle only. All three are low after a cycle with no message.
- R4: In the flat model (format bits 31:28 = 4'b1111), a non-broadcast message is accepted when msg_mda AND ID[31:24] is nonzero, and ignored otherwise.
- R5: In the flat model, msg_mda = 8'hFF is accepted whatever the ID holds, with or without msg_lowpri.
- R6: In the cluster model (format bits 31:28 = 4'b0000), a non-broadcast message is accepted when msg_mda[7:4] equals ID[31:28] and msg_mda[3:0] AND ID[27:24] is nonzero. Otherwise it is ignored.
- R7: In the cluster model, a cluster field of 4'hF matches any cluster, and the member mask still applies. msg_mda = 8'hFF without msg_lowpri is accepted by every unit, even one with an empty member field.
- R8: In the cluster model, msg_mda = 8'hFF with msg_lowpri set produces error and not accept.
- R9: With any other model code, every message is ignored and sets cfg_err. cfg_err stays high until the format register is written. A message with an illegal model in the same cycle as that write keeps it set.
- R10: A message that arrives in the same cycle as a register write is judged against the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 logical ID, 1 format |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| msg_valid | input | 1 | Incoming message present this cycle |
| msg_mda | input | 8 | Message destination address |
| msg_lowpri | input | 1 | Message uses lowest-priority delivery |
| accept | output | 1 | One-cycle pulse: message is for this unit |
| ignore | output | 1 | One-cycle pulse: message is not for this unit |
| error | output | 1 | One-cycle pulse: unsupported lowest-priority cluster broadcast |
| cfg_err | output | 1 | Sticky flag: message seen under an illegal model code |

## Verification
The bench sweeps all 256 destinations, with and without lowest priority, over twenty flat identities and sixty-four cluster identities. It targets the following corner cases:
- Cluster 15: a design that treats it as an ordinary cluster number drops partial broadcasts.
- All-ones destination against an empty member field: a design that runs it through the member AND ignores a broadcast it must take.
- Lowest-priority all-ones in cluster mode: a design that gets this wrong accepts where it must flag an error.
- Register write in the same cycle as a message: a design that forwards the new value decides with the wrong identity.
- Clearing the sticky configuration flag while an illegal message lands in the same cycle: a design that gives the clear priority loses that fault.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  typedef enum logic [1:0] {
    MODEL_FLAT    = 2'd0,
    MODEL_CLUSTER = 2'd1,
    MODEL_BAD     = 2'd2
  } model_e;

  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_ACCEPT = 2'd1,
    DEC_IGNORE = 2'd2,
    DEC_ERROR  = 2'd3
  } dec_e;

endpackage

// File: rtl/ldm_regs.sv
module ldm_regs
  import ldm_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ID_W   = 8,
  parameter int MODE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [ID_W-1:0]  id_q,
  output model_e           model,
  output logic             fmt_wr
);

  localparam int ID_LO   = REG_W - ID_W;
  localparam int MODE_LO = REG_W - MODE_W;

  logic [MODE_W-1:0] mode_q;

  // Only the meaningful fields are stored; the rest read as constants (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      mode_q <= '1;
    end else if (wr_en) begin
      if (!addr) id_q   <= wdata[REG_W-1:ID_LO];
      else       mode_q <= wdata[REG_W-1:MODE_LO];
    end
  end

  assign fmt_wr = wr_en && addr;

  always_comb begin
    if (!addr) rdata = {id_q, {ID_LO{1'b0}}};
    else       rdata = {mode_q, {MODE_LO{1'b1}}};
  end

  always_comb begin
    if (&mode_q)       model = MODEL_FLAT;
    else if (~|mode_q) model = MODEL_CLUSTER;
    else               model = MODEL_BAD;
  end

endmodule

// File: rtl/ldm_decode.sv
module ldm_decode
  import ldm_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  model_e          model,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] mda,
  input  logic            lowpri,
  output dec_e            dec,
  output logic            bcast,
  output logic            cl_match,
  output logic            mem_hit,
  output logic            flat_hit
);

  localparam int HALF = ID_W / 2;

  function automatic logic any_common(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    return |(a & b);
  endfunction

  function automatic logic cluster_sel(input logic [HALF-1:0] want, input logic [HALF-1:0] mine);
    return (&want) || (want == mine);
  endfunction

  assign bcast    = &mda;
  assign flat_hit = any_common(mda, id);
  assign cl_match = cluster_sel(mda[ID_W-1:HALF], id[ID_W-1:HALF]);
  assign mem_hit  = |(mda[HALF-1:0] & id[HALF-1:0]);

  always_comb begin
    dec = DEC_IGNORE;
    unique case (model)
      MODEL_FLAT: begin
        if (bcast || flat_hit) dec = DEC_ACCEPT;
      end
      MODEL_CLUSTER: begin
        if (bcast)                     dec = lowpri ? DEC_ERROR : DEC_ACCEPT;
        else if (cl_match && mem_hit)  dec = DEC_ACCEPT;
      end
      default: dec = DEC_IGNORE;
    endcase
  end

endmodule

// File: rtl/ldest_match.sv
module ldest_match
  import ldm_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ID_W   = 8,
  parameter int MODE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             msg_valid,
  input  logic [ID_W-1:0]  msg_mda,
  input  logic             msg_lowpri,
  output logic             accept,
  output logic             ignore,
  output logic             error,
  output logic             cfg_err
);

  logic [ID_W-1:0] id_q;
  model_e          model;
  logic            fmt_wr;
  dec_e            dec;
  logic            bcast, cl_match, mem_hit, flat_hit;
  logic            bad_msg;

  ldm_regs #(.REG_W(REG_W), .ID_W(ID_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .id_q(id_q), .model(model),
    .fmt_wr(fmt_wr)
  );

  // Decision uses the pre-write register values (R10)
  ldm_decode #(.ID_W(ID_W)) u_dec (
    .model(model), .id(id_q), .mda(msg_mda), .lowpri(msg_lowpri),
    .dec(dec), .bcast(bcast), .cl_match(cl_match), .mem_hit(mem_hit),
    .flat_hit(flat_hit)
  );

  assign bad_msg = msg_valid && (model == MODEL_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept <= 1'b0;
      ignore <= 1'b0;
      error  <= 1'b0;
    end else begin
      accept <= msg_valid && (dec == DEC_ACCEPT);
      ignore <= msg_valid && (dec == DEC_IGNORE);
      error  <= msg_valid && (dec == DEC_ERROR);
    end
  end

  // Sticky flag: a new fault wins over a clearing write (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_err <= 1'b0;
    else if (bad_msg) cfg_err <= 1'b1;
    else if (fmt_wr)  cfg_err <= 1'b0;
  end

  AST_ONE_HOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, ignore, error})); // R3
  AST_MSG_GETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> $countones({accept, ignore, error}) == 1); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !accept && !ignore && !error); // R3
  AST_FLAT_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && model == MODEL_FLAT && bcast |=> accept); // R5
  AST_CL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && model == MODEL_CLUSTER && !cl_match |=> !accept); // R6
  AST_LP_BCAST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && model == MODEL_CLUSTER && bcast && msg_lowpri |=> error && !accept); // R8
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && model == MODEL_BAD |=> ignore && cfg_err); // R9

endmodule

// File: tb/ldest_match_tb.sv
module ldest_match_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_mda = '0;
  logic        msg_lowpri = 1'b0;
  logic        accept, ignore, error, cfg_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench mirror of the programmable state
  logic [7:0] m_id = 8'h00;
  logic [3:0] m_mode = 4'hF;
  logic       m_err = 1'b0;
  logic       pend = 1'b0;
  logic [2:0] exp3 = 3'b000;   // {accept, ignore, error}
  string      exp_tag = "R3";

  always #5 clk = ~clk;

  ldest_match u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_mda(msg_mda), .msg_lowpri(msg_lowpri), .accept(accept),
    .ignore(ignore), .error(error), .cfg_err(cfg_err)
  );

  function automatic logic [2:0] model_dec(input logic [3:0] mode, input logic [7:0] id,
                                           input logic [7:0] d, input logic lp);
    int cl, mem, mycl, mymem;
    bit hit;
    if (mode == 4'hF) begin
      if (d == 8'd255) return 3'b100;
      hit = 0;
      for (int i = 0; i < 8; i++) if (d[i] && id[i]) hit = 1;
      return hit ? 3'b100 : 3'b010;
    end else if (mode == 4'h0) begin
      if (d == 8'd255) return lp ? 3'b001 : 3'b100;
      cl = d / 16; mem = d % 16; mycl = id / 16; mymem = id % 16;
      hit = 0;
      for (int i = 0; i < 4; i++) if (((mem >> i) & 1) == 1 && ((mymem >> i) & 1) == 1) hit = 1;
      return ((cl == 15 || cl == mycl) && hit) ? 3'b100 : 3'b010;
    end
    return 3'b010;
  endfunction

  function automatic string tag_for(input logic [3:0] mode, input logic [7:0] d, input logic lp);
    if (mode == 4'hF) return (d == 8'd255) ? "R5" : "R4";
    if (mode == 4'h0) begin
      if (d == 8'd255) return lp ? "R8" : "R7";
      return (d[7:4] == 4'hF) ? "R7" : "R6";
    end
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // One cycle: check previous outcome, then drive new inputs
  task automatic cyc(input logic wr, input logic a, input logic [31:0] wd,
                     input logic mv, input logic [7:0] d, input logic lp);
    logic bad_old;
    @(negedge clk);
    if (pend) begin
      check(exp_tag, {29'd0, accept, ignore, error}, {29'd0, exp3});
      check("R9", {31'd0, cfg_err}, {31'd0, m_err});
    end
    reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    msg_valid = mv; msg_mda = d; msg_lowpri = lp;
    // expectation from the old register values (R10)
    exp3 = mv ? model_dec(m_mode, m_id, d, lp) : 3'b000;
    exp_tag = mv ? tag_for(m_mode, d, lp) : "R3";
    pend = 1'b1;
    bad_old = (m_mode != 4'hF) && (m_mode != 4'h0);
    if (mv && bad_old) m_err = 1'b1;
    else if (wr && a)  m_err = 1'b0;
    if (wr && !a) m_id = wd[31:24];
    if (wr && a)  m_mode = wd[31:28];
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] wd);
    cyc(1'b1, a, wd, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic msg(input logic [7:0] d, input logic lp);
    cyc(1'b0, 1'b0, 32'h0, 1'b1, d, lp);
  endtask

  task automatic rd_check(input logic a);
    cyc(1'b0, a, 32'h0, 1'b0, 8'h00, 1'b0);
    #1;
    check("R2", reg_rdata, a ? {m_mode, 28'hFFFFFFF} : {m_id, 24'h0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {29'd0, accept, ignore, error}, 32'd0);
    check("R1", {31'd0, cfg_err}, 32'd0);
    reg_addr = 1'b0; #1; check("R1", reg_rdata, 32'h00000000);
    reg_addr = 1'b1; #1; check("R1", reg_rdata, 32'hFFFFFFFF);
    // R1/R5: zero ID takes only broadcast
    msg(8'hFF, 1'b0); msg(8'h01, 1'b0); msg(8'hFF, 1'b1);

    // R2: read-back masking
    wr_reg(1'b0, 32'hA5123456); rd_check(1'b0);
    wr_reg(1'b1, 32'h0ABCDEF0); rd_check(1'b1);
    wr_reg(1'b1, 32'hF0000000); rd_check(1'b1);
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 1'b0); // R3 idle cycle

    // R4/R5: flat sweep
    for (int k = 0; k < 20; k++) begin
      logic [7:0] id;
      id = (k < 8) ? 8'(1 << k) : (k == 8) ? 8'h00 : (k == 9) ? 8'hFF : 8'(k * 29 + 3);
      wr_reg(1'b0, {id, 24'h0});
      for (int d = 0; d < 256; d++)
        for (int lp = 0; lp < 2; lp++) msg(8'(d), lp[0]);
    end

    // R6/R7/R8: cluster sweep
    wr_reg(1'b1, 32'h00000000);
    rd_check(1'b1);
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 16; m++) begin
        logic [3:0] cl;
        cl = (c == 0) ? 4'd0 : (c == 1) ? 4'd7 : (c == 2) ? 4'd14 : 4'd15;
        wr_reg(1'b0, {cl, 4'(m), 24'h0});
        for (int d = 0; d < 256; d++)
          for (int lp = 0; lp < 2; lp++) msg(8'(d), lp[0]);
      end

    // R10: write and message in the same cycle
    wr_reg(1'b1, 32'hF0000000);
    wr_reg(1'b0, 32'h01000000);
    cyc(1'b1, 1'b0, 32'h02000000, 1'b1, 8'h01, 1'b0); // old ID 01 -> accept
    msg(8'h01, 1'b0);                                 // new ID 02 -> ignore
    cyc(1'b1, 1'b1, 32'h00000000, 1'b1, 8'hFF, 1'b1); // still flat -> accept
    msg(8'hFF, 1'b1);                                 // now cluster -> error

    // R9: illegal model codes
    for (int mo = 1; mo < 15; mo++) begin
      wr_reg(1'b1, {4'(mo), 28'h0});
      msg(8'hFF, 1'b0); msg(8'h02, 1'b0);
      cyc(1'b1, 1'b1, {4'(mo), 28'h0}, 1'b1, 8'h02, 1'b0); // fault wins over clear
      wr_reg(1'b1, 32'hF0000000);                          // clears flag
      msg(8'hFF, 1'b0);
    end
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 1'b0);
    finish_run();
  end

endmodule